// File: doc/BRIEF.md
# Pipeline Operand Forwarding Select

This block is the bypass-select logic of a five-stage in-order integer pipeline whose branches and jumps resolve in decode. For each of the two source operands it decides where the operand value should come from. It makes that decision twice: once for the instruction now in execute, and once for the instruction now in decode, where branch operands are compared and jump-register targets are formed. The block is purely combinational. Its outputs steer data multiplexers that lie outside it.

A producer qualifies as a bypass source only if its register write-enable is set and its destination index is non-zero and equal to the consumer's source index. When both the memory-stage and the write-back-stage producer qualify, the memory-stage one is chosen because it is the younger instruction. A load sitting in the memory stage has no data yet. If such a load would be the chosen producer, the select falls back to "none" and the separate stall logic holds the consumer.

Top module: `fwd_select_unit`

## Requirements
- R1: Every select output uses the code 2'b00 for register-file value, 2'b01 for memory-stage result and 2'b10 for write-back-stage result; 2'b11 never appears.
- R2: A select is 2'b01 when the memory-stage write-enable is 1, the memory-stage destination equals the source index, that index is non-zero and the memory-stage producer is not a load.
- R3: A select is 2'b10 when the write-back write-enable is 1, its destination equals the non-zero source index, and the memory stage does not qualify as a match for that index.
- R4: When both the memory-stage and the write-back-stage producers match the same source index, the memory stage takes precedence and 2'b10 is not produced.
- R5: A source index of 0 always yields 2'b00, whatever the producers hold.
- R6: A producer whose write-enable is 0 is never selected, even when its destination index matches.
- R7: When the memory-stage producer is an enabled load whose destination matches a non-zero source index, the select is 2'b00, even if write-back also matches.
- R8: The decode-stage selects depend only on the decode source indices and the execute-stage selects depend only on the execute source indices. Changing one stage's indices leaves the other stage's selects unchanged.
- R9: The second-operand selects follow the same rules as the first-operand selects, independently of the first operand's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1_i | input | IDX_W | First source index of the instruction in decode |
| id_rs2_i | input | IDX_W | Second source index of the instruction in decode |
| ex_rs1_i | input | IDX_W | First source index of the instruction in execute |
| ex_rs2_i | input | IDX_W | Second source index of the instruction in execute |
| mem_rd_i | input | IDX_W | Destination index of the memory-stage instruction |
| mem_wen_i | input | 1 | Register write-enable of the memory-stage instruction |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| wb_rd_i | input | IDX_W | Destination index of the write-back instruction |
| wb_wen_i | input | 1 | Register write-enable of the write-back instruction |
| ex_sel_a_o | output | 2 | Execute-stage first-operand select |
| ex_sel_b_o | output | 2 | Execute-stage second-operand select |
| id_sel_a_o | output | 2 | Decode-stage first-operand select |
| id_sel_b_o | output | 2 | Decode-stage second-operand select |

## Verification
The block has no state, so any fault in it shows on a select output in the same cycle as the inputs that expose it. A wrong priority, a missed x0 check or a load that is not blocked sends a stale or not-yet-valid value into a comparison or an ALU operand in that same cycle. The bench drives dense index collisions from a narrow index range and compares all four selects every cycle against a behavioural model. Directed cases cover x0, disabled producers, load blocking and cross-stage independence.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    FWD_NONE = 2'b00,
    FWD_MEM  = 2'b01,
    FWD_WB   = 2'b10
  } fwd_sel_e;

  // Priority: the younger producer (MEM) decides first; a blocked MEM match
  // suppresses the older WB value, which would be stale.
  function automatic fwd_sel_e resolve_source(input logic mem_hit,
                                              input logic mem_blocked,
                                              input logic wb_hit);
    if (mem_hit)     return mem_blocked ? FWD_NONE : FWD_MEM;
    else if (wb_hit) return FWD_WB;
    else             return FWD_NONE;
  endfunction

endpackage

// File: rtl/fwd_producer_match.sv
module fwd_producer_match #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic             dst_wen,
  output logic             hit
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  function automatic logic idx_match(input logic [IDX_W-1:0] s,
                                     input logic [IDX_W-1:0] d,
                                     input logic             w);
    return w && (s != ZERO_IDX) && (s == d);
  endfunction

  assign hit = idx_match(src_idx, dst_idx, dst_wen);

  always_comb begin
    if (src_idx == ZERO_IDX)
      assert_no_zero_hit_R5: assert (!hit);
    if (!dst_wen)
      assert_no_hit_disabled_R6: assert (!hit);
  end
endmodule

// File: rtl/fwd_lane.sv
module fwd_lane
  import fwd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_wen,
  input  logic             mem_load,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_wen,
  output fwd_sel_e         sel
);
  logic mem_hit;
  logic wb_hit;
  logic mem_blocked;

  fwd_producer_match #(.IDX_W(IDX_W)) u_mem_match (
    .src_idx(src_idx), .dst_idx(mem_rd), .dst_wen(mem_wen), .hit(mem_hit)
  );

  fwd_producer_match #(.IDX_W(IDX_W)) u_wb_match (
    .src_idx(src_idx), .dst_idx(wb_rd), .dst_wen(wb_wen), .hit(wb_hit)
  );

  assign mem_blocked = mem_load;
  assign sel         = resolve_source(mem_hit, mem_blocked, wb_hit);

  always_comb begin
    assert_code_legal_R1: assert (sel != 2'b11);
    if (sel == FWD_MEM)
      assert_mem_qualified_R2: assert (mem_wen && !mem_load && (mem_rd == src_idx) && (src_idx != '0));
    if (sel == FWD_WB)
      assert_wb_qualified_R3: assert (wb_wen && (wb_rd == src_idx) && (src_idx != '0)
                                      && !(mem_wen && (mem_rd == src_idx)));
    if (mem_hit && wb_hit)
      assert_mem_precedence_R4: assert (sel != FWD_WB);
    if (mem_wen && mem_load && (mem_rd == src_idx) && (src_idx != '0))
      assert_load_blocks_R7: assert (sel == FWD_NONE);
  end
endmodule

// File: rtl/fwd_select_unit.sv
module fwd_select_unit
  import fwd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] id_rs1_i,
  input  logic [IDX_W-1:0] id_rs2_i,
  input  logic [IDX_W-1:0] ex_rs1_i,
  input  logic [IDX_W-1:0] ex_rs2_i,
  input  logic [IDX_W-1:0] mem_rd_i,
  input  logic             mem_wen_i,
  input  logic             mem_load_i,
  input  logic [IDX_W-1:0] wb_rd_i,
  input  logic             wb_wen_i,
  output logic [1:0]       ex_sel_a_o,
  output logic [1:0]       ex_sel_b_o,
  output logic [1:0]       id_sel_a_o,
  output logic [1:0]       id_sel_b_o
);
  // Lane order: 0 = EX rs1, 1 = EX rs2, 2 = ID rs1, 3 = ID rs2
  localparam int NUM_OPND  = 2;
  localparam int NUM_STAGE = 2;
  localparam int NUM_LANE  = NUM_OPND * NUM_STAGE;

  logic [IDX_W-1:0] lane_src [NUM_LANE];
  fwd_sel_e         lane_sel [NUM_LANE];

  assign lane_src[0] = ex_rs1_i;
  assign lane_src[1] = ex_rs2_i;
  assign lane_src[2] = id_rs1_i;
  assign lane_src[3] = id_rs2_i;

  for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
    fwd_lane #(.IDX_W(IDX_W)) u_lane (
      .src_idx (lane_src[g]),
      .mem_rd  (mem_rd_i),
      .mem_wen (mem_wen_i),
      .mem_load(mem_load_i),
      .wb_rd   (wb_rd_i),
      .wb_wen  (wb_wen_i),
      .sel     (lane_sel[g])
    );
  end

  assign ex_sel_a_o = lane_sel[0];
  assign ex_sel_b_o = lane_sel[1];
  assign id_sel_a_o = lane_sel[2];
  assign id_sel_b_o = lane_sel[3];

  // R8 / R9: equal indices in different lanes must give equal selects
  always_comb begin
    if (ex_rs1_i == id_rs1_i)
      assert_stage_symmetry_R8: assert (ex_sel_a_o == id_sel_a_o);
    if (ex_rs1_i == ex_rs2_i)
      assert_operand_symmetry_R9: assert (ex_sel_a_o == ex_sel_b_o);
  end
endmodule

// File: tb/tb_fwd_select_unit.sv
`timescale 1ns/1ps
module tb_fwd_select_unit;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [IDX_W-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, mem_rd, wb_rd;
  logic mem_wen, mem_load, wb_wen;
  logic [1:0] ex_a, ex_b, id_a, id_b;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  fwd_select_unit #(.IDX_W(IDX_W)) dut (
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .mem_rd_i(mem_rd), .mem_wen_i(mem_wen), .mem_load_i(mem_load),
    .wb_rd_i(wb_rd), .wb_wen_i(wb_wen),
    .ex_sel_a_o(ex_a), .ex_sel_b_o(ex_b), .id_sel_a_o(id_a), .id_sel_b_o(id_b)
  );

  // Behavioural reference: newest qualifying producer wins; a load there means "wait".
  function automatic int model(input int src);
    int mem_ok, wb_ok;
    if (src == 0) return 0;
    mem_ok = (mem_wen === 1'b1) && (int'(mem_rd) == src);
    wb_ok  = (wb_wen === 1'b1) && (int'(wb_rd) == src);
    if (mem_ok) return mem_load ? 0 : 1;
    if (wb_ok)  return 2;
    return 0;
  endfunction

  function automatic string tag_for(input int src);
    if (src == 0) return "R5";
    if (mem_wen && int'(mem_rd) == src && mem_load) return "R7";
    if (mem_wen && int'(mem_rd) == src && wb_wen && int'(wb_rd) == src) return "R4";
    if (mem_wen && int'(mem_rd) == src) return "R2";
    if (wb_wen && int'(wb_rd) == src) return "R3";
    return "R6";
  endfunction

  task automatic check(input string lane, input string req, input logic [1:0] act, input int exp);
    n_checks++;
    if (act === 2'b11) begin
      n_fail++;
      $display("FAIL R1 %s: illegal code actual=%0d expected=%0d", lane, act, exp);
    end else if (int'(act) != exp || $isunknown(act)) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, lane, act, exp);
    end
  endtask

  task automatic check_all();
    check("ex_a", tag_for(int'(ex_rs1)), ex_a, model(int'(ex_rs1)));
    check("ex_b", {tag_for(int'(ex_rs2)), "/R9"}, ex_b, model(int'(ex_rs2)));
    check("id_a", tag_for(int'(id_rs1)), id_a, model(int'(id_rs1)));
    check("id_b", {tag_for(int'(id_rs2)), "/R9"}, id_b, model(int'(id_rs2)));
  endtask

  task automatic drive(input int i1, i2, e1, e2, md, input bit mw, ml, input int wd, input bit ww);
    @(posedge clk); #1;
    id_rs1 = IDX_W'(i1); id_rs2 = IDX_W'(i2); ex_rs1 = IDX_W'(e1); ex_rs2 = IDX_W'(e2);
    mem_rd = IDX_W'(md); mem_wen = mw; mem_load = ml; wb_rd = IDX_W'(wd); wb_wen = ww;
    @(negedge clk);
  endtask

  initial begin
    id_rs1 = '0; id_rs2 = '0; ex_rs1 = '0; ex_rs2 = '0;
    mem_rd = '0; wb_rd = '0; mem_wen = 0; mem_load = 0; wb_wen = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: all selects 2'b00 (R1)
    check("ex_a", "R1", ex_a, 0); check("id_b", "R1", id_b, 0);

    // R2: MEM forward on both stages
    drive(3, 4, 3, 7, 3, 1, 0, 9, 1); check_all();
    // R3: WB forward only
    drive(9, 2, 9, 9, 3, 1, 0, 9, 1); check_all();
    // R4: both match, MEM wins
    drive(6, 6, 6, 6, 6, 1, 0, 6, 1); check_all();
    check("id_a", "R4", id_a, 1);
    // R5: x0 as destination and source
    drive(0, 0, 0, 0, 0, 1, 0, 0, 1); check_all();
    check("ex_a", "R5", ex_a, 0);
    // R6: matching but disabled producers
    drive(5, 5, 5, 5, 5, 0, 0, 5, 0); check_all();
    check("ex_b", "R6", ex_b, 0);
    drive(5, 8, 5, 8, 5, 0, 0, 5, 1); check_all();
    check("ex_a", "R6", ex_a, 2);
    // R7: load in MEM blocks, WB also matching
    drive(11, 12, 11, 1, 11, 1, 1, 11, 1); check_all();
    check("id_a", "R7", id_a, 0); check("ex_a", "R7", ex_a, 0);
    // R7 side: load flag with a non-matching MEM leaves WB path open
    drive(12, 12, 12, 12, 11, 1, 1, 12, 1); check_all();
    check("id_b", "R7", id_b, 2);
    // R8: change EX indices only, ID selects must hold
    drive(4, 5, 4, 5, 4, 1, 0, 5, 1); check_all();
    drive(4, 5, 0, 31, 4, 1, 0, 5, 1);
    check("id_a", "R8", id_a, 1); check("id_b", "R8", id_b, 2); check_all();
    drive(20, 21, 0, 31, 4, 1, 0, 5, 1);
    check("ex_a", "R8", ex_a, 0); check("ex_b", "R8", ex_b, 0); check_all();
    // R9: rs2 matches, rs1 does not
    drive(1, 14, 2, 14, 14, 1, 0, 1, 1); check_all();
    check("ex_b", "R9", ex_b, 1); check("id_a", "R9", id_a, 2);

    // Dense random collisions from a narrow index range
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom);
      drive(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 3)), r[0], r[1],
            int'($urandom_range(0, 3)), r[2]);
      check_all();
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule